// File: doc/BRIEF.md
# ATA Task-File Shadow Register Bank

This block holds a host-side copy of the legacy ATA command-block and control-block registers and supports 48-bit LBA addressing. Software reaches it through a byte-wide register port: a select line picks the command block or the control block, and a 3-bit offset picks the register. Each of the five parameter registers (features, sector count, LBA low, LBA mid and LBA high) keeps its last two written bytes. Software writes the high-order byte first and the low-order byte second. A read returns the newer or the older byte, depending on the high-order-byte select bit in the device control register.

A write to the command register freezes a 20-byte host-to-device register frame image. The image packs the command, device, control and both halves of every 48-bit field into fixed byte lanes. The block offers the image on a parallel output under a valid/ready handshake. Moving the frame over a serial link, data transfer and interrupts are handled elsewhere.

Top module: `ata_taskfile_shadow`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears every current and previous byte slot, the device register and device control to zero, and drops `fis_valid`.
- R2: A command-block write at offset 1 (features), 2 (sector count), 3 (LBA low), 4 (LBA mid) or 5 (LBA high) moves the register's current byte into its previous slot and stores the written byte as current.
- R3: While bit 7 of device control is 0, a command-block read at offsets 1 to 5 returns that register's current (most recently written) byte.
- R4: While bit 7 of device control is 1, a command-block read at offsets 1 to 5 returns that register's previous (earlier written) byte.
- R5: A control-block write at offset 6 stores the whole byte into device control. Any command-block write, at any offset, clears device control bit 7 and leaves its other bits as they were.
- R6: A command-block read at offset 7 and a control-block read at offset 6 both return `dev_status`, whatever the value of device control bit 7.
- R7: A command-block write at offset 7 while `fis_valid` is low raises `fis_valid` at the next edge. The latched image is made of bytes, with byte i on `fis_data[8i+7:8i]`:
  - byte 0 = 27h, byte 1 = 80h, byte 2 = written command, byte 3 = current features;
  - bytes 4, 5, 6 = current LBA low, mid, high; byte 7 = device;
  - bytes 8, 9, 10 = previous LBA low, mid, high; byte 11 = previous features;
  - byte 12 = current sector count, byte 13 = previous sector count, byte 14 = 0, byte 15 = device control as it stood before the write;
  - bytes 16 to 19 = 0.
- R8: While `fis_valid` is high and `fis_ready` is low, `fis_valid` and `fis_data` stay unchanged. An edge with both high drops `fis_valid`.
- R9: A command-register write while `fis_valid` is high leaves `fis_data` unchanged.
- R10: The device register (command-block offset 6) stores a single byte and reads back the same byte whatever bit 7 of device control holds. A command-block read at offset 0 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| io_wr | input | 1 | Register write strobe |
| io_ctrl_sel | input | 1 | 1 selects the control block, 0 the command block |
| io_addr | input | 3 | Register offset within the selected block |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data for the addressed register (combinational) |
| dev_status | input | 8 | Status byte shadowed from the device side |
| fis_valid | output | 1 | Frame image is available |
| fis_ready | input | 1 | Consumer accepts the frame image |
| fis_data | output | 160 | Packed 20-byte host-to-device register frame image |

## Verification
A slot that shifts wrongly or fails to shift shows at `io_rdata` on the first read after the second write to that register. The fault shows with one select state and not the other, so the bench reads every register with bit 7 both clear and set. A stuck or lost select bit returns the wrong byte on the very next read after a device-control write or after a command-block write that should clear it. Frame-packing faults appear in the `fis_data` byte lanes one edge after the command write. The bench fills every field with a distinct value so that a swapped lane cannot match by accident. Handshake faults show up as `fis_valid` dropping or the image changing while ready is low.

// File: rtl/ata_tf_pkg.sv
package ata_tf_pkg;
    localparam int TF_BYTE_W   = 8;
    localparam int TF_ADDR_W   = 3;
    localparam int TF_SLOTS    = 5;
    localparam int TF_FIS_BYTES = 20;

    // Command-block offsets (legacy layout; read/write meaning depends on it)
    localparam logic [TF_ADDR_W-1:0] OFS_DATA   = 3'd0;
    localparam logic [TF_ADDR_W-1:0] OFS_FEAT   = 3'd1;
    localparam logic [TF_ADDR_W-1:0] OFS_COUNT  = 3'd2;
    localparam logic [TF_ADDR_W-1:0] OFS_LBA_LO = 3'd3;
    localparam logic [TF_ADDR_W-1:0] OFS_LBA_MD = 3'd4;
    localparam logic [TF_ADDR_W-1:0] OFS_LBA_HI = 3'd5;
    localparam logic [TF_ADDR_W-1:0] OFS_DEV    = 3'd6;
    localparam logic [TF_ADDR_W-1:0] OFS_CMD    = 3'd7;
    // Control-block offset of device control / alternate status
    localparam logic [TF_ADDR_W-1:0] OFS_DCTL   = 3'd6;

    // Slot index = offset - 1
    localparam int SLOT_FEAT  = 0;
    localparam int SLOT_COUNT = 1;
    localparam int SLOT_LBA_LO = 2;
    localparam int SLOT_LBA_MD = 3;
    localparam int SLOT_LBA_HI = 4;

    localparam int HOB_BIT = 7;
    localparam logic [TF_BYTE_W-1:0] FIS_TYPE_H2D = 8'h27;
    localparam logic [TF_BYTE_W-1:0] FIS_FLAG_CMD = 8'h80;
endpackage

// File: rtl/tf_fifo2.sv
module tf_fifo2 #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] din,
    output logic [W-1:0] cur,
    output logic [W-1:0] prev
);
    typedef struct packed {
        logic [W-1:0] cur;
        logic [W-1:0] prev;
    } pair_t;

    pair_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (push) begin
            st_d.prev = st_q.cur;
            st_d.cur  = din;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign cur  = st_q.cur;
    assign prev = st_q.prev;
endmodule

// File: rtl/tf_fis_pack.sv
module tf_fis_pack
    import ata_tf_pkg::*;
#(
    parameter int W = TF_BYTE_W,
    parameter int N = TF_SLOTS,
    parameter int NB = TF_FIS_BYTES,
    localparam int IMG_W = NB * W
) (
    input  logic [W-1:0]        cmd,
    input  logic [W-1:0]        dev,
    input  logic [W-1:0]        dctl,
    input  logic [N-1:0][W-1:0] slot_cur,
    input  logic [N-1:0][W-1:0] slot_prev,
    output logic [IMG_W-1:0]    image
);
    logic [NB-1:0][W-1:0] lanes;

    always_comb begin
        lanes     = '0;
        lanes[0]  = FIS_TYPE_H2D;
        lanes[1]  = FIS_FLAG_CMD;
        lanes[2]  = cmd;
        lanes[3]  = slot_cur[SLOT_FEAT];
        lanes[4]  = slot_cur[SLOT_LBA_LO];
        lanes[5]  = slot_cur[SLOT_LBA_MD];
        lanes[6]  = slot_cur[SLOT_LBA_HI];
        lanes[7]  = dev;
        lanes[8]  = slot_prev[SLOT_LBA_LO];
        lanes[9]  = slot_prev[SLOT_LBA_MD];
        lanes[10] = slot_prev[SLOT_LBA_HI];
        lanes[11] = slot_prev[SLOT_FEAT];
        lanes[12] = slot_cur[SLOT_COUNT];
        lanes[13] = slot_prev[SLOT_COUNT];
        lanes[15] = dctl;
    end

    genvar gb;
    generate
        for (gb = 0; gb < NB; gb++) begin : g_lane
            assign image[gb*W +: W] = lanes[gb];
        end
    endgenerate
endmodule

// File: rtl/tf_read_mux.sv
module tf_read_mux
    import ata_tf_pkg::*;
#(
    parameter int W = TF_BYTE_W,
    parameter int N = TF_SLOTS,
    parameter int AW = TF_ADDR_W
) (
    input  logic                ctrl_sel,
    input  logic [AW-1:0]       addr,
    input  logic                hob,
    input  logic [N-1:0][W-1:0] slot_cur,
    input  logic [N-1:0][W-1:0] slot_prev,
    input  logic [W-1:0]        dev,
    input  logic [W-1:0]        status,
    output logic [W-1:0]        rdata
);
    always_comb begin
        rdata = '0;
        if (ctrl_sel) begin
            if (addr == OFS_DCTL) rdata = status;
        end else begin
            for (int i = 0; i < N; i++) begin
                if (addr == AW'(i + 1)) rdata = hob ? slot_prev[i] : slot_cur[i];
            end
            if (addr == OFS_DEV) rdata = dev;
            if (addr == OFS_CMD) rdata = status;
        end
    end
endmodule

// File: rtl/ata_taskfile_shadow.sv
module ata_taskfile_shadow
    import ata_tf_pkg::*;
#(
    parameter int DATA_W = TF_BYTE_W,
    parameter int ADDR_W = TF_ADDR_W,
    parameter int SLOTS  = TF_SLOTS,
    localparam int FIS_W = TF_FIS_BYTES * DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              io_wr,
    input  logic              io_ctrl_sel,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [DATA_W-1:0] io_wdata,
    output logic [DATA_W-1:0] io_rdata,
    input  logic [DATA_W-1:0] dev_status,
    output logic              fis_valid,
    input  logic              fis_ready,
    output logic [FIS_W-1:0]  fis_data
);
    typedef struct packed {
        logic [DATA_W-1:0] dctl;
        logic [DATA_W-1:0] dev;
        logic              valid;
        logic [FIS_W-1:0]  image;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [SLOTS-1:0][DATA_W-1:0] slot_cur;
    logic [SLOTS-1:0][DATA_W-1:0] slot_prev;
    logic [SLOTS-1:0]             slot_push;
    logic [FIS_W-1:0]             image_next;
    logic                         cmd_blk_wr;
    logic                         cmd_wr;

    assign cmd_blk_wr = io_wr && !io_ctrl_sel;
    assign cmd_wr     = cmd_blk_wr && (io_addr == OFS_CMD);

    genvar gs;
    generate
        for (gs = 0; gs < SLOTS; gs++) begin : g_slot
            assign slot_push[gs] = cmd_blk_wr && (io_addr == ADDR_W'(gs + 1));
            tf_fifo2 #(.W(DATA_W)) u_pair (
                .clk  (clk),
                .rst  (rst),
                .push (slot_push[gs]),
                .din  (io_wdata),
                .cur  (slot_cur[gs]),
                .prev (slot_prev[gs])
            );
        end
    endgenerate

    tf_fis_pack #(.W(DATA_W), .N(SLOTS), .NB(TF_FIS_BYTES)) u_pack (
        .cmd       (io_wdata),
        .dev       (ctl_q.dev),
        .dctl      (ctl_q.dctl),
        .slot_cur  (slot_cur),
        .slot_prev (slot_prev),
        .image     (image_next)
    );

    tf_read_mux #(.W(DATA_W), .N(SLOTS), .AW(ADDR_W)) u_rd (
        .ctrl_sel  (io_ctrl_sel),
        .addr      (io_addr),
        .hob       (ctl_q.dctl[HOB_BIT]),
        .slot_cur  (slot_cur),
        .slot_prev (slot_prev),
        .dev       (ctl_q.dev),
        .status    (dev_status),
        .rdata     (io_rdata)
    );

    always_comb begin
        ctl_d = ctl_q;
        if (cmd_blk_wr) ctl_d.dctl[HOB_BIT] = 1'b0;
        if (io_wr && io_ctrl_sel && (io_addr == OFS_DCTL)) ctl_d.dctl = io_wdata;
        if (cmd_blk_wr && (io_addr == OFS_DEV)) ctl_d.dev = io_wdata;
        if (ctl_q.valid && fis_ready) ctl_d.valid = 1'b0;
        if (cmd_wr && !ctl_q.valid) begin
            ctl_d.valid = 1'b1;
            ctl_d.image = image_next;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ctl_q <= '0;
        else     ctl_q <= ctl_d;
    end

    assign fis_valid = ctl_q.valid;
    assign fis_data  = ctl_q.image;
endmodule

// File: rtl/tf_shadow_chk.sv
module tf_shadow_chk
    import ata_tf_pkg::*;
(
    input logic         clk,
    input logic         rst,
    input logic         io_wr,
    input logic         io_ctrl_sel,
    input logic [2:0]   io_addr,
    input logic [7:0]   io_rdata,
    input logic [7:0]   dev_status,
    input logic         fis_valid,
    input logic         fis_ready,
    input logic [159:0] fis_data
);
    AST_RESET_DROPS_VALID: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !fis_valid); // R1
    AST_ALT_STATUS_PASS: assert property (@(posedge clk) disable iff (rst)
        (io_ctrl_sel && io_addr == OFS_DCTL) |-> io_rdata == dev_status); // R6
    AST_STATUS_PASS: assert property (@(posedge clk) disable iff (rst)
        (!io_ctrl_sel && io_addr == OFS_CMD) |-> io_rdata == dev_status); // R6
    AST_CMD_RAISES_VALID: assert property (@(posedge clk) disable iff (rst)
        (io_wr && !io_ctrl_sel && io_addr == OFS_CMD && !fis_valid) |=> fis_valid); // R7
    AST_FIS_HEADER: assert property (@(posedge clk) disable iff (rst)
        fis_valid |-> (fis_data[7:0] == FIS_TYPE_H2D && fis_data[15:8] == FIS_FLAG_CMD)); // R7
    AST_VALID_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (fis_valid && !fis_ready) |=> fis_valid); // R8
    AST_IMAGE_STABLE: assert property (@(posedge clk) disable iff (rst)
        (fis_valid && !fis_ready) |=> $stable(fis_data)); // R8
    AST_VALID_RETIRES: assert property (@(posedge clk) disable iff (rst)
        (fis_valid && fis_ready) |=> !fis_valid); // R8
    AST_BUSY_CMD_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (fis_valid && io_wr && !io_ctrl_sel && io_addr == OFS_CMD) |=> $stable(fis_data)); // R9
endmodule

bind ata_taskfile_shadow tf_shadow_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .io_wr       (io_wr),
    .io_ctrl_sel (io_ctrl_sel),
    .io_addr     (io_addr),
    .io_rdata    (io_rdata),
    .dev_status  (dev_status),
    .fis_valid   (fis_valid),
    .fis_ready   (fis_ready),
    .fis_data    (fis_data)
);

// File: tb/sim_ata_taskfile_shadow.sv
`timescale 1ns/1ps
module sim_ata_taskfile_shadow;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         io_wr = 1'b0;
    logic         io_ctrl_sel = 1'b0;
    logic [2:0]   io_addr = 3'd0;
    logic [7:0]   io_wdata = 8'd0;
    logic [7:0]   io_rdata;
    logic [7:0]   dev_status = 8'h50;
    logic         fis_valid;
    logic         fis_ready = 1'b0;
    logic [159:0] fis_data;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // Reference model state
    logic [7:0] m_cur [5];
    logic [7:0] m_prev[5];
    logic [7:0] m_dctl, m_dev;
    logic       m_valid;
    logic [159:0] m_img;

    always #2 clk = ~clk;   // 250 MHz

    ata_taskfile_shadow u0 (
        .clk(clk), .rst(rst), .io_wr(io_wr), .io_ctrl_sel(io_ctrl_sel),
        .io_addr(io_addr), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .dev_status(dev_status), .fis_valid(fis_valid), .fis_ready(fis_ready),
        .fis_data(fis_data)
    );

    task automatic chk(input string req, input logic [159:0] act, input logic [159:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 5; i++) begin m_cur[i] = 8'd0; m_prev[i] = 8'd0; end
        m_dctl = 8'd0; m_dev = 8'd0; m_valid = 1'b0; m_img = '0;
    endtask

    function automatic logic [159:0] build_img(input logic [7:0] cmd);
        logic [159:0] v = '0;
        v[7:0]     = 8'h27;       v[15:8]    = 8'h80;
        v[23:16]   = cmd;         v[31:24]   = m_cur[0];
        v[39:32]   = m_cur[2];    v[47:40]   = m_cur[3];
        v[55:48]   = m_cur[4];    v[63:56]   = m_dev;
        v[71:64]   = m_prev[2];   v[79:72]   = m_prev[3];
        v[87:80]   = m_prev[4];   v[95:88]   = m_prev[0];
        v[103:96]  = m_cur[1];    v[111:104] = m_prev[1];
        v[127:120] = m_dctl;
        return v;
    endfunction

    task automatic wr(input logic c, input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        io_ctrl_sel = c; io_addr = a; io_wdata = d; io_wr = 1'b1;
        if (!c && a == 3'd7 && !m_valid) begin m_valid = 1'b1; m_img = build_img(d); end
        if (!c) m_dctl[7] = 1'b0;
        if (c && a == 3'd6) m_dctl = d;
        if (!c && a == 3'd6) m_dev = d;
        if (!c && a >= 3'd1 && a <= 3'd5) begin
            m_prev[a-1] = m_cur[a-1]; m_cur[a-1] = d;
        end
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    function automatic logic [7:0] exp_rd(input logic c, input logic [2:0] a);
        if (c) return (a == 3'd6) ? dev_status : 8'd0;
        if (a >= 3'd1 && a <= 3'd5) return m_dctl[7] ? m_prev[a-1] : m_cur[a-1];
        if (a == 3'd6) return m_dev;
        if (a == 3'd7) return dev_status;
        return 8'd0;
    endfunction

    task automatic rd_chk(input string req, input logic c, input logic [2:0] a);
        io_ctrl_sel = c; io_addr = a;
        #0.5;
        chk(req, {152'd0, io_rdata}, {152'd0, exp_rd(c, a)});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1: reset state
        chk("R1 fis_valid after reset", {159'd0, fis_valid}, 160'd0);
        for (int a = 0; a < 8; a++) rd_chk("R1 reset read", 1'b0, 3'(a));

        // R2/R3/R4: sweep each slot over many byte pairs
        for (int r = 1; r <= 5; r++) begin
            for (int k = 0; k < 16; k++) begin
                logic [7:0] hi = 8'(r * 53 + k * 17);
                logic [7:0] lo = 8'(~hi + k * 3 + 1);
                wr(1'b0, 3'(r), hi);
                wr(1'b0, 3'(r), lo);
                rd_chk("R2 R3 current byte", 1'b0, 3'(r));
                wr(1'b1, 3'd6, 8'h80);
                rd_chk("R4 previous byte", 1'b0, 3'(r));
                // R10: device register unaffected by select bit
                rd_chk("R10 device read hob=1", 1'b0, 3'd6);
            end
        end

        // R6: status and alternate status with both select states
        for (int s = 0; s < 256; s += 37) begin
            dev_status = 8'(s);
            wr(1'b1, 3'd6, 8'h80);
            rd_chk("R6 alt status hob=1", 1'b1, 3'd6);
            rd_chk("R6 status hob=1", 1'b0, 3'd7);
            wr(1'b1, 3'd6, 8'h02);
            rd_chk("R6 alt status hob=0", 1'b1, 3'd6);
            rd_chk("R6 status hob=0", 1'b0, 3'd7);
        end
        dev_status = 8'h50;

        // R10: device register and data offset
        wr(1'b0, 3'd6, 8'hE5);
        rd_chk("R10 device hob=0", 1'b0, 3'd6);
        rd_chk("R10 data offset zero", 1'b0, 3'd0);

        // R5: any command-block write clears the select bit
        wr(1'b1, 3'd6, 8'h86);
        wr(1'b0, 3'd2, 8'h3C);
        chk("R5 hob cleared, other bits kept", {152'd0, m_dctl}, 160'h06);
        for (int r = 1; r <= 5; r++) rd_chk("R5 read after clear", 1'b0, 3'(r));
        wr(1'b1, 3'd6, 8'h80);
        wr(1'b0, 3'd6, 8'hA0);
        rd_chk("R5 device write clears hob", 1'b0, 3'd4);

        // R7: fill every field distinctly, then issue command
        for (int r = 1; r <= 5; r++) begin
            wr(1'b0, 3'(r), 8'(8'h10 * r + 1));
            wr(1'b0, 3'(r), 8'(8'h10 * r + 8));
        end
        wr(1'b0, 3'd6, 8'h4F);
        wr(1'b1, 3'd6, 8'h0A);
        wr(1'b0, 3'd7, 8'h25);
        chk("R7 fis_valid raised", {159'd0, fis_valid}, 160'd1);
        chk("R7 fis image", fis_data, m_img);

        // R8: hold while ready low
        repeat (5) @(negedge clk);
        chk("R8 valid held", {159'd0, fis_valid}, 160'd1);
        chk("R8 image held", fis_data, m_img);

        // R9: command while pending ignored
        wr(1'b0, 3'd3, 8'h99);
        wr(1'b0, 3'd7, 8'hEC);
        chk("R9 image unchanged", fis_data, m_img);
        chk("R9 valid still high", {159'd0, fis_valid}, 160'd1);

        // R8: handshake retires frame
        @(negedge clk); fis_ready = 1'b1;
        @(negedge clk); fis_ready = 1'b0; m_valid = 1'b0;
        chk("R8 valid dropped", {159'd0, fis_valid}, 160'd0);

        // R7: second frame after retire, with select bit set beforehand
        wr(1'b1, 3'd6, 8'h84);
        wr(1'b0, 3'd7, 8'h24);
        chk("R7 second image", fis_data, m_img);
        chk("R7 second valid", {159'd0, fis_valid}, 160'd1);

        // R1: reset mid-operation
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0; model_reset();
        chk("R1 valid cleared", {159'd0, fis_valid}, 160'd0);
        for (int a = 1; a < 7; a++) rd_chk("R1 slots cleared", 1'b0, 3'(a));
        wr(1'b1, 3'd6, 8'h80);
        for (int a = 1; a < 6; a++) rd_chk("R1 previous slots cleared", 1'b0, 3'(a));

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule